// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects four interrupt sources, one raster source and three DMA channel sources, into a single active-low interrupt line for a CPU. A combined control/status register serves two purposes. Its low bits hold the three DMA channel enables, and its high bits show which sources are pending. Pending bits are active low and are cleared by writing 1 to them. A second register supplies the upper five bits of the interrupt vector and an option bit that decides whether DMA interrupts clear themselves when acknowledged.

When the CPU acknowledges an interrupt, the block picks the highest-priority pending source and latches an 8-bit vector. The vector carries the register's upper bits, a 2-bit source code and a zero in bit 0. The vector output then holds that value until the next acknowledge that finds a source pending. The block also drives per-channel pulses that mark the moment a DMA channel's pending bit is cleared. Each channel's sequencer can use these pulses to resume.

Top module: `vic_top`

## Requirements
- R1: After reset the channel enables are 000, the status register reads 0xF0, the vector register reads 0x01, `irq_n` is 1 and `vector` is 0x00.
- R2: A write to the status register (`reg_sel`=0) loads `wr_data[2:0]` into the enables of channels 2..0. A `stop_evt[i]` pulse clears enable i at the next edge, and it takes precedence over a simultaneous write.
- R3: A raster request, or a DMA request on an enabled channel, marks that source pending. Status bit 7 (raster), bit 6 (channel 2), bit 5 (channel 1) or bit 4 (channel 0) then reads 0. A request from a disabled channel is ignored.
- R4: Writing 1 to a status interrupt bit clears that source's pending state, and writing 0 has no effect. `dma_clr[i]` is high in the cycle in which channel i's pending bit is being cleared, whether by a write or by an acknowledge.
- R5: `irq_n` is 0 exactly while at least one source is pending. It falls in the cycle after the request that set the pending bit.
- R6: On an acknowledge with a source pending, `vector` becomes {vector register bits 7..3, code, 0} one cycle later. The priority order, highest first, is raster, channel 2, channel 1, channel 0. The codes are raster=11, ch2=00, ch1=01 and ch0=10.
- R7: An acknowledge always clears a winning raster source. It clears a winning DMA source only when vector register bit 0 is 1. No other pending source is touched.
- R8: `vector` stays unchanged between acknowledges, even when higher-priority sources arrive. An acknowledge with nothing pending leaves it unchanged.
- R9: If a request and a clear reach the same source in the same cycle, the source stays pending.
- R10: A write to the vector register (`reg_sel`=1) stores bits 7..3 and bit 0, and bits 2..1 read back 0. Status bit 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raster_req | input | 1 | Raster interrupt request pulse |
| dma_req | input | 3 | Per-channel DMA interrupt request pulses |
| stop_evt | input | 3 | Per-channel stop-instruction pulses that clear the enable |
| reg_sel | input | 1 | Register select: 0 status/control, 1 vector register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq_n | output | 1 | Active-low interrupt line |
| vector | output | 8 | Latched interrupt vector |
| chan_en | output | 3 | DMA channel enables |
| dma_clr | output | 3 | Pulse while a DMA channel's pending bit is being cleared |

## Verification
The assertions assume that `ack` is a single-cycle strobe and that the request and stop inputs are synchronous to `clk`. The stimulus meets both: every input is changed only just after a falling edge and is held for exactly one full cycle. Each priority case starts from an empty pending set, so the outcome of each acknowledge depends only on the pattern that the table row injects.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_DMA    = 3;
  localparam int NUM_SRC    = NUM_DMA + 1;
  localparam int RASTER_IDX = NUM_DMA;
  localparam int DATA_W     = 8;
  localparam int CODE_W     = 2;
  localparam int IVR_HI_W   = DATA_W - CODE_W - 1;

  // Highest index wins: raster, then channel 2, 1, 0.
  function automatic logic [NUM_SRC-1:0] pick_winner(input logic [NUM_SRC-1:0] pend);
    logic [NUM_SRC-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (pend[i]) w = NUM_SRC'(1) << i;
    return w;
  endfunction

  function automatic logic [CODE_W-1:0] src_code(input logic [NUM_SRC-1:0] onehot);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (onehot[i]) c = (i == RASTER_IDX) ? {CODE_W{1'b1}} : CODE_W'(NUM_DMA - 1 - i);
    return c;
  endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic                ivr_wr,
  input  logic [NUM_DMA-1:0]  en_d,
  input  logic [IVR_HI_W-1:0] ivr_hi_d,
  input  logic                auto_d,
  input  logic [NUM_DMA-1:0]  stop_evt,
  output logic [NUM_DMA-1:0]  chan_en,
  output logic [IVR_HI_W-1:0] ivr_hi,
  output logic                auto_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_en  <= '0;
      ivr_hi   <= '0;
      auto_clr <= 1'b1;
    end else begin
      chan_en <= (ctl_wr ? en_d : chan_en) & ~stop_evt;
      if (ivr_wr) begin
        ivr_hi   <= ivr_hi_d;
        auto_clr <= auto_d;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_DMA; g++) begin : g_stop_chk
      AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt[g] |=> !chan_en[g]); // R2
    end
  endgenerate
endmodule

// File: rtl/vic_pending.sv
module vic_pending
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set,
  input  logic [NUM_SRC-1:0] cpu_clr,
  input  logic [NUM_SRC-1:0] ack_clr,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] cleared
);
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      logic clr;
      assign clr        = cpu_clr[g] | ack_clr[g];
      assign cleared[g] = pend[g] & clr & ~set[g];

      always_ff @(posedge clk) begin
        if (!rst_n) pend[g] <= 1'b0;
        else        pend[g] <= set[g] | (pend[g] & ~clr);
      end

      AST_REQ_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        set[g] && clr |=> pend[g]); // R9
      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !set[g] |=> !pend[g]); // R4
    end
  endgenerate
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  pend,
  input  logic                ack,
  input  logic [IVR_HI_W-1:0] ivr_hi,
  input  logic                auto_clr,
  output logic [DATA_W-1:0]   vector,
  output logic [NUM_SRC-1:0]  ack_clr
);
  logic [NUM_SRC-1:0] win;
  logic               any_pend;
  logic               take;

  assign win      = pick_winner(pend);
  assign any_pend = |pend;
  assign take     = ack & any_pend;
  assign ack_clr  = take ? (win & {1'b1, {NUM_DMA{auto_clr}}}) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)    vector <= '0;
    else if (take) vector <= {ivr_hi, src_code(win), 1'b0};
  end

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(vector)); // R8
  AST_RASTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ack && pend[RASTER_IDX] |=> vector[2:1] == 2'b11); // R6
  AST_RASTER_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    ack && pend[RASTER_IDX] |-> $onehot(ack_clr)); // R7
  AST_ACK_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> $onehot0(ack_clr)); // R7
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                raster_req,
  input  logic [NUM_DMA-1:0]  dma_req,
  input  logic [NUM_DMA-1:0]  stop_evt,
  input  logic                reg_sel,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                ack,
  output logic                irq_n,
  output logic [DATA_W-1:0]   vector,
  output logic [NUM_DMA-1:0]  chan_en,
  output logic [NUM_DMA-1:0]  dma_clr
);
  localparam int PEND_LSB = DATA_W - NUM_SRC;

  logic                ctl_wr, ivr_wr, auto_clr;
  logic [IVR_HI_W-1:0] ivr_hi;
  logic [NUM_SRC-1:0]  set, cpu_clr, ack_clr, pend, cleared;

  assign ctl_wr  = wr_en & ~reg_sel;
  assign ivr_wr  = wr_en & reg_sel;
  assign set     = {raster_req, dma_req & chan_en};
  assign cpu_clr = ctl_wr ? wr_data[DATA_W-1:PEND_LSB] : '0;
  assign irq_n   = ~|pend;
  assign dma_clr = cleared[NUM_DMA-1:0];
  assign rd_data = reg_sel ? {ivr_hi, {CODE_W{1'b0}}, auto_clr}
                           : {~pend, {(PEND_LSB-NUM_DMA){1'b0}}, chan_en};

  vic_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ivr_wr(ivr_wr),
    .en_d(wr_data[NUM_DMA-1:0]), .ivr_hi_d(wr_data[DATA_W-1:DATA_W-IVR_HI_W]),
    .auto_d(wr_data[0]), .stop_evt(stop_evt), .chan_en(chan_en),
    .ivr_hi(ivr_hi), .auto_clr(auto_clr)
  );

  vic_pending u_pend (
    .clk(clk), .rst_n(rst_n), .set(set), .cpu_clr(cpu_clr),
    .ack_clr(ack_clr), .pend(pend), .cleared(cleared)
  );

  vic_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .ack(ack), .ivr_hi(ivr_hi),
    .auto_clr(auto_clr), .vector(vector), .ack_clr(ack_clr)
  );

  AST_IRQ_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    raster_req |=> !irq_n); // R5
  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n && !raster_req && !(|(dma_req & chan_en)) |=> irq_n); // R3
endmodule

// File: tb/vic_top_bench.sv
module vic_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raster_req = 1'b0;
  logic [2:0] dma_req = '0;
  logic [2:0] stop_evt = '0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ack = 1'b0;
  logic       irq_n;
  logic [7:0] vector;
  logic [2:0] chan_en;
  logic [2:0] dma_clr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vic_top u_vic_top (
    .clk(clk), .rst_n(rst_n), .raster_req(raster_req), .dma_req(dma_req),
    .stop_evt(stop_evt), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ack(ack), .irq_n(irq_n), .vector(vector),
    .chan_en(chan_en), .dma_clr(dma_clr)
  );

  // {pattern raster,ch2,ch1,ch0 ; expected code}
  localparam logic [5:0] PRIO_TBL [8] = '{
    {4'b0001, 2'b10}, {4'b0010, 2'b01}, {4'b0100, 2'b00}, {4'b1000, 2'b11},
    {4'b0111, 2'b00}, {4'b1111, 2'b11}, {4'b0011, 2'b01}, {4'b0101, 2'b00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    raster_req = 1'b0; dma_req = '0; stop_evt = '0; wr_en = 1'b0; ack = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    step();
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel; #1 d = rd_data;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, r); chk("R1 status", r, 8'hF0);
    rd(1'b1, r); chk("R1 ivr", r, 8'h01);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 vector", vector, 8'h00);
    chk("R1 chan_en", {5'd0, chan_en}, 8'h00);

    // R10 vector register fields
    wr(1'b1, 8'hFF); rd(1'b1, r); chk("R10 ivr unused bits", r, 8'hF9);
    wr(1'b1, 8'hA8); rd(1'b1, r); chk("R10 ivr store", r, 8'hA8);
    wr(1'b0, 8'h0F); rd(1'b0, r); chk("R10 status bit3", r, 8'hF7);
    chk("R2 enable write", {5'd0, chan_en}, 8'h07);

    // R2 stop clears, and wins over a write
    stop_evt = 3'b010; step();
    chk("R2 stop clears", {5'd0, chan_en}, 8'h05);
    stop_evt = 3'b001; wr(1'b0, 8'h07);
    chk("R2 stop beats write", {5'd0, chan_en}, 8'h06);

    // R3 disabled channel ignored
    wr(1'b0, 8'h03);
    dma_req = 3'b100; step();
    rd(1'b0, r); chk("R3 disabled ignored", r, 8'hF3);
    chk("R3 irq stays high", {7'd0, irq_n}, 8'h01);
    wr(1'b0, 8'h07);

    // R6 R7 R5 priority table, auto-clear off
    for (int i = 0; i < 8; i++) begin
      logic [3:0] pat, left;
      logic [1:0] code;
      pat = PRIO_TBL[i][5:2]; code = PRIO_TBL[i][1:0];
      raster_req = pat[3]; dma_req = pat[2:0]; step();
      chk("R5 irq low", {7'd0, irq_n}, 8'h00);
      rd(1'b0, r); chk("R3 status pending", r, {~pat, 4'h7});
      ack = 1'b1; step();
      chk("R6 vector", vector, 8'hA8 | {5'd0, code, 1'b0});
      left = pat[3] ? {1'b0, pat[2:0]} : pat;
      rd(1'b0, r); chk("R7 after ack", r, {~left, 4'h7});
      wr(1'b0, 8'hF7);
      chk("R5 irq high", {7'd0, irq_n}, 8'h01);
    end

    // R7 R4 auto-clear on
    wr(1'b1, 8'hA9);
    dma_req = 3'b011; step();
    ack = 1'b1; #1 chk("R4 clr pulse on ack", {5'd0, dma_clr}, 8'h02);
    step();
    chk("R6 ch1 vector", vector, 8'hAA);
    rd(1'b0, r); chk("R7 dma auto-cleared", r, 8'hE7);

    // R8 hold
    raster_req = 1'b1; step();
    chk("R8 vector held", vector, 8'hAA);
    wr(1'b0, 8'hF7);
    ack = 1'b1; step();
    chk("R8 empty ack", vector, 8'hAA);

    // R4 write 0 no effect, write 1 clears with pulse
    dma_req = 3'b001; step();
    wr(1'b0, 8'h07); rd(1'b0, r); chk("R4 write0 no effect", r, 8'hE7);
    reg_sel = 1'b0; wr_data = 8'h17; wr_en = 1'b1;
    #1 chk("R4 clr pulse on write", {5'd0, dma_clr}, 8'h01);
    step();
    rd(1'b0, r); chk("R4 write1 clears", r, 8'hF7);

    // R9 request beats clear
    dma_req = 3'b001; step();
    dma_req = 3'b001; reg_sel = 1'b0; wr_data = 8'h17; wr_en = 1'b1;
    #1 chk("R9 no clr pulse", {5'd0, dma_clr}, 8'h00);
    step();
    rd(1'b0, r); chk("R9 stays pending", r, 8'hE7);
    chk("R9 irq low", {7'd0, irq_n}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule